// File: doc/BRIEF.md
# Burst-of-Four Split-Port Synchronous SRAM Model

This block models a synchronous static memory whose read data and write data travel on separate ports, while both kinds of operation share a single command and address port. Each accepted operation moves exactly four data words. A new operation can start in every command cycle, so reads and writes can be interleaved and both data ports can stay busy at the same time.

The model runs on one fast clock. Two fast ticks make one command cycle, and each tick stands for one edge of a double-rate transfer. The strobes and the base address are sampled only on the first tick of a command cycle, and the `cmd_tick` output marks that tick. Write words, each with a per-byte mask, are taken on four consecutive ticks. Read words come back on four consecutive ticks, together with a valid flag.

Whether a command is admitted depends on what the previous command cycle admitted. This rule keeps a burst that is already running from being cut short or restarted.

Top module: `qb4_sram`

## Requirements
- R1: Strobes and the address are sampled only at an edge where `cmd_tick` was high. `cmd_tick` is high in the first tick after reset and then alternates every tick. Low strobes presented on the other ticks have no effect.
- R2: With both `rd_n` and `wr_n` high, the command cycle starts nothing, and the next command cycle is free to accept either kind of operation.
- R3: A low `rd_n` starts a read unless the previous command cycle accepted a read. When the read is refused, nothing starts, not even a write with `wr_n` low.
- R4: A low `wr_n` together with a high `rd_n` starts a write unless the previous command cycle accepted a write. A refused write leaves the array unchanged.
- R5: Beat k (k = 0..3) of a burst uses the array word at index `{addr, k[1:0]}`, so beats proceed in ascending order from index bits [1:0] = 0.
- R6: For a write sampled at edge E, beat k's data and mask are captured at edge E+2+k.
- R7: For a read sampled at edge E, beat k appears on `rdata` right after edge E+3+k, and `rvalid` is high for exactly those ticks. Reads accepted every other command cycle give an unbroken `rvalid`.
- R8: `wmask_n[0]` low writes bits 8:0 and `wmask_n[1]` low writes bits 17:9. A high mask bit leaves that byte as stored. Any mask pattern is allowed on any beat.
- R9: After reset, `rvalid` is 0 and `rdata` is 0. `rdata` keeps its last value whenever `rvalid` is low.
- R10: A read accepted in the cycle right after a write to the same address returns the newly written words on every beat. A read accepted in the cycle right before such a write returns the old words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two ticks per command cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | AW | Burst base address (array index without the two beat bits) |
| wdata | input | 18 | Write data word for the current tick |
| wmask_n | input | 2 | Active-low byte write enables for the current tick |
| cmd_tick | output | 1 | High during the tick whose closing edge samples a command |
| rdata | output | 18 | Read data word |
| rvalid | output | 1 | High while a read beat is on `rdata` |

## Verification
If the acceptance memory is wrong, a read or write is admitted or refused in the wrong cycle. A refused read shows up as a missing `rvalid` window three edges later. An admitted or refused write shows up as a wrong word in the next read of that address. A beat counter or a base register that is off sends data to the wrong index, and this appears as a mismatch in the first beat read back from the affected word. A phase error shifts `rvalid` by one tick and is caught in the very next command cycle. Stale or bypassed coherence appears as old data on the beats of a read that directly follows a write.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
  localparam int BEATS  = 4;
  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/qb4_cmd_ctl.sv
module qb4_cmd_ctl
  import qb4_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic cmd_tick,
  output logic rd_go,
  output logic wr_go
);
  logic ph;
  op_e  last_op;

  function automatic logic admit(input logic req, input op_e want, input op_e prev);
    return req && (want != prev);
  endfunction

  assign cmd_tick = ~ph;
  assign rd_go    = cmd_tick && admit(~rd_n, OP_READ, last_op);
  assign wr_go    = cmd_tick && admit(rd_n && ~wr_n, OP_WRITE, last_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= 1'b0;
      last_op <= OP_IDLE;
    end else begin
      ph <= ~ph;
      if (cmd_tick)
        last_op <= rd_go ? OP_READ : (wr_go ? OP_WRITE : OP_IDLE);
    end
  end
endmodule

// File: rtl/qb4_burst_seq.sv
module qb4_burst_seq
  import qb4_pkg::*;
#(
  parameter int AW   = 4,
  parameter int LEAD = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        base,
  output logic                 beat_on,
  output logic [AW+BEAT_W-1:0] beat_addr
);
  localparam int DLY_W = $clog2(LEAD + 1);
  localparam int LW    = $clog2(BEATS + 1);

  logic [DLY_W-1:0]  dly;
  logic [AW-1:0]     pend_base;
  logic [AW-1:0]     base_q;
  logic [LW-1:0]     left;
  logic [BEAT_W-1:0] idx;
  logic              load;

  function automatic logic [AW+BEAT_W-1:0] join_index(input logic [AW-1:0] b,
                                                     input logic [BEAT_W-1:0] k);
    return {b, k};
  endfunction

  assign load      = (dly == DLY_W'(1));
  assign beat_on   = (left != '0);
  assign beat_addr = join_index(base_q, idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly       <= '0;
      pend_base <= '0;
      base_q    <= '0;
      left      <= '0;
      idx       <= '0;
    end else begin
      if (start) begin
        dly       <= DLY_W'(LEAD);
        pend_base <= base;
      end else if (dly != '0) begin
        dly <= dly - DLY_W'(1);
      end
      if (load) begin
        left   <= LW'(BEATS);
        idx    <= '0;
        base_q <= pend_base;
      end else if (beat_on) begin
        left <= left - LW'(1);
        idx  <= idx + BEAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/qb4_array.sv
module qb4_array #(
  parameter int IW     = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IW-1:0]            waddr,
  input  logic [BYTE_W*NBYTES-1:0] wdata,
  input  logic [NBYTES-1:0]        wmask_n,
  input  logic                     re,
  input  logic [IW-1:0]            raddr,
  output logic [BYTE_W*NBYTES-1:0] rdata,
  output logic                     rvalid
);
  localparam int DW    = BYTE_W * NBYTES;
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] mem [DEPTH];

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [NBYTES-1:0] keep);
    logic [DW-1:0] res;
    res = old_w;
    for (int b = 0; b < NBYTES; b++)
      if (!keep[b]) res[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
    return res;
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= merge(mem[waddr], wdata, wmask_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/qb4_sram.sv
module qb4_sram
  import qb4_pkg::*;
#(
  parameter int AW     = 4,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_n,
  input  logic                     wr_n,
  input  logic [AW-1:0]            addr,
  input  logic [BYTE_W*NBYTES-1:0] wdata,
  input  logic [NBYTES-1:0]        wmask_n,
  output logic                     cmd_tick,
  output logic [BYTE_W*NBYTES-1:0] rdata,
  output logic                     rvalid
);
  localparam int DW = BYTE_W * NBYTES;
  localparam int IW = AW + BEAT_W;

  logic          rd_go, wr_go;
  logic          rd_on, wr_on;
  logic [IW-1:0] rd_idx, wr_idx;

  qb4_cmd_ctl u_cmd (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n),
    .cmd_tick(cmd_tick), .rd_go(rd_go), .wr_go(wr_go)
  );

  qb4_burst_seq #(.AW(AW), .LEAD(1)) u_wseq (
    .clk(clk), .rst_n(rst_n), .start(wr_go), .base(addr),
    .beat_on(wr_on), .beat_addr(wr_idx)
  );

  qb4_burst_seq #(.AW(AW), .LEAD(2)) u_rseq (
    .clk(clk), .rst_n(rst_n), .start(rd_go), .base(addr),
    .beat_on(rd_on), .beat_addr(rd_idx)
  );

  qb4_array #(.IW(IW), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .we(wr_on), .waddr(wr_idx), .wdata(wdata), .wmask_n(wmask_n),
    .re(rd_on), .raddr(rd_idx), .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: rtl/qb4_sram_chk.sv
module qb4_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          cmd_tick,
  input logic          rd_go,
  input logic          wr_go,
  input logic          rd_on,
  input logic          wr_on,
  input logic          rvalid,
  input logic [DW-1:0] rdata
);
  p_tick_fall_r1: assert property (@(posedge clk) disable iff (!rst_n) cmd_tick |=> !cmd_tick);
  p_tick_rise_r1: assert property (@(posedge clk) disable iff (!rst_n) !cmd_tick |=> cmd_tick);
  p_off_tick_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_tick |-> !(rd_go || wr_go));
  p_deselect_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |-> !(rd_go || wr_go));
  p_single_op_r3: assert property (@(posedge clk) disable iff (!rst_n) !(rd_go && wr_go));
  p_read_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n) rd_go |=> ##1 !rd_go);
  p_write_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n) wr_go |=> ##1 !wr_go);
  p_write_window_r6: assert property (@(posedge clk) disable iff (!rst_n) wr_go |=> ##1 wr_on);
  p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n) rd_go |=> ##3 rvalid);
  p_read_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |=> rvalid ##1 rvalid ##1 rvalid);
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n) rd_on |=> rvalid);
  p_valid_drops_r7: assert property (@(posedge clk) disable iff (!rst_n) !rd_on |=> !rvalid);
  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n) !rvalid |-> $stable(rdata));
endmodule

bind qb4_sram qb4_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .cmd_tick(cmd_tick),
  .rd_go(rd_go), .wr_go(wr_go), .rd_on(rd_on), .wr_on(wr_on),
  .rvalid(rvalid), .rdata(rdata)
);

// File: tb/qb4_sram_test.sv
module qb4_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 18;
  localparam int NIDX = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_n = 1'b1;
  logic wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] wmask_n = 2'b11;
  logic cmd_tick, rvalid;
  logic [DW-1:0] rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  qb4_sram uut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .wmask_n(wmask_n), .cmd_tick(cmd_tick),
    .rdata(rdata), .rvalid(rvalid)
  );

  int n_tests = 0;
  int n_fail = 0;
  int e = 0;
  int prev_op = 0;
  bit done = 0;
  string req = "R9";
  logic exp_rv = 1'b0;
  logic [DW-1:0] exp_rd = '0;
  logic [DW-1:0] mm [NIDX];
  logic [DW-1:0] wdat_at [int];
  logic [1:0] wmsk_at [int];
  int widx_at [int];
  int ridx_at [int];
  logic [DW-1:0] cd [4];
  logic [1:0] cm [4];

  function automatic logic [DW-1:0] apply_mask(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                               logic [1:0] m);
    logic [DW-1:0] r = old_w;
    if (m[0] == 1'b0) r[8:0] = new_w[8:0];
    if (m[1] == 1'b0) r[17:9] = new_w[17:9];
    return r;
  endfunction

  task automatic check(string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // one fast tick: drive inputs for edge e, advance the model, sample at the next negedge
  task automatic tick(logic c_rd, logic c_wr, int a);
    int op;
    if (e % 2 == 0) begin
      rd_n = c_rd; wr_n = c_wr; addr = AW'(a);
    end else begin
      rd_n = 1'b0; wr_n = 1'b0; addr = AW'($urandom);  // noise off the command tick (R1)
    end
    if (wdat_at.exists(e)) begin
      wdata = wdat_at[e]; wmask_n = wmsk_at[e];
    end else begin
      wdata = DW'($urandom); wmask_n = 2'($urandom);
    end
    if (e % 2 == 0) begin
      op = 0;
      if (!c_rd && prev_op != 1) op = 1;
      else if (c_rd && !c_wr && prev_op != 2) op = 2;
      prev_op = op;
      for (int k = 0; k < 4; k++) begin
        if (op == 1) ridx_at[e+3+k] = a * 4 + k;
        if (op == 2) begin
          widx_at[e+2+k] = a * 4 + k;
          wdat_at[e+2+k] = cd[k];
          wmsk_at[e+2+k] = cm[k];
        end
      end
    end
    if (ridx_at.exists(e)) begin
      exp_rv = 1'b1;
      exp_rd = mm[ridx_at[e]];
    end else begin
      exp_rv = 1'b0;
    end
    if (widx_at.exists(e))
      mm[widx_at[e]] = apply_mask(mm[widx_at[e]], wdat_at[e], wmsk_at[e]);
    e++;
    @(negedge clk);
    check("rvalid", DW'(rvalid), DW'(exp_rv));
    check(exp_rv ? "rdata beat" : "rdata hold", rdata, exp_rd);
    check("cmd_tick", DW'(cmd_tick), DW'(e % 2 == 0));
  endtask

  task automatic cycle(logic c_rd, logic c_wr, int a);
    tick(c_rd, c_wr, a);
    tick(1'b1, 1'b1, 0);
  endtask

  task automatic wr(int a, logic [1:0] m);
    for (int k = 0; k < 4; k++) begin
      cd[k] = DW'($urandom);
      cm[k] = m;
    end
    cycle(1'b1, 1'b0, a);
  endtask

  task automatic rd(int a);
    cycle(1'b0, 1'b1, a);
  endtask

  task automatic nop();
    cycle(1'b1, 1'b1, 0);
  endtask

  initial begin
    for (int i = 0; i < NIDX; i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R9";
    check("reset rvalid", DW'(rvalid), '0);
    check("reset rdata", rdata, '0);
    check("reset cmd_tick", DW'(cmd_tick), DW'(1));

    req = "R6";
    for (int a = 0; a < 16; a++) begin
      wr(a, 2'b00);
      nop();
    end
    req = "R5";
    for (int a = 0; a < 16; a++) begin
      rd(a);
      wr((a + 5) % 16, 2'b00);
    end

    req = "R8";
    for (int k = 0; k < 4; k++) cd[k] = DW'($urandom);
    cm[0] = 2'b10; cm[1] = 2'b01; cm[2] = 2'b00; cm[3] = 2'b11;
    cycle(1'b1, 1'b0, 6);
    rd(6);
    wr(11, 2'b01);
    rd(11);
    wr(12, 2'b11);
    rd(12);

    req = "R3";
    rd(3);
    cycle(1'b0, 1'b0, 7);
    nop();
    rd(7);

    req = "R4";
    wr(5, 2'b00);
    wr(5, 2'b00);
    rd(5);

    req = "R2";
    rd(2); nop(); rd(4);
    wr(1, 2'b00); nop(); wr(1, 2'b00);
    rd(1);

    req = "R10";
    wr(9, 2'b00); rd(9);
    rd(10); wr(10, 2'b00); rd(10);

    req = "R7";
    rd(0); wr(1, 2'b00); rd(2); wr(3, 2'b00); rd(4); wr(8, 2'b00); rd(8);

    req = "R1";
    for (int i = 0; i < 300; i++) begin
      for (int k = 0; k < 4; k++) begin
        cd[k] = DW'($urandom);
        cm[k] = 2'($urandom);
      end
      cycle(1'($urandom), 1'($urandom), int'($urandom % 16));
    end
    repeat (4) nop();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements): got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule